// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Output

This block buffers 18-bit words between two unrelated clock domains. The producer side runs on its own free-running clock. The consumer side runs on a second clock, which may have any frequency or phase relative to the first and may even be the same clock. Storage is a 256-entry inferred dual-port array. The write and read pointers cross between the domains as Gray codes through two-flop synchronizers. Full is decided in the write domain and empty in the read domain, each from the other side's synchronized pointer.

The read side ends in a registered head-of-queue stage. When a word reaches an empty buffer, that word moves into the output register by itself, whatever the read inputs are doing. An output-ready flag then marks it as valid. A read consumes the word at the register and pulls the next word in, if there is one. When nothing follows, the last word read stays on the output.

Writing needs one active-high and one active-low qualifier. Reading needs a read request and two output gates, all active-low. A single asynchronous active-low reset clears both sides. The ready flags come out of reset on defined edges of their own clocks.

Top module: `dual_clk_fifo`

## Requirements
- R1: A word on `wr_data` is stored on a rising edge of `wclk` only when `wr_en_hi` is 1, `wr_en_lo_n` is 0 and `in_rdy` is 1. Any other combination of the two qualifiers stores nothing.
- R2: The word on `rd_data` is consumed on a rising edge of `rclk` only when `out_rdy` is 1 and `rd_take_n`, `oe_a_n` and `oe_b_n` are all 0. Otherwise `out_rdy` stays 1 and `rd_data` holds its value.
- R3: The first word written into an empty buffer reaches `rd_data` without any read request, even while `rd_take_n`, `oe_a_n` and `oe_b_n` are all 1.
- R4: After a word is written into an empty buffer, `out_rdy` rises on the third rising edge of `rclk` that follows the write edge. The word appears on `rd_data` on that same edge.
- R5: `in_rdy` is 0 while reset is asserted. After `rst_n` is released, `in_rdy` rises on the second rising edge of `wclk`.
- R6: The block holds 2^ADDR_W words in the array plus one in the output register. With the output register loaded and the array full, `in_rdy` is 0 and write attempts change nothing. `in_rdy` returns to 1 once reads free space.
- R7: While `out_rdy` is 0, `rd_data` keeps the last word that was consumed.
- R8: `rd_drive` is 1 exactly when `oe_a_n` and `oe_b_n` are both 0. Either gate at 1 blocks consumption.
- R9: `half_full` is 1 when the write side sees at least half of the array occupied (2^ADDR_W/2 words), and 0 otherwise.
- R10: Under independent clocks and arbitrary qualifier patterns, words leave the block in the order they were accepted, with none lost and none duplicated.
- R11: Asserting `rst_n` low, asynchronously to both clocks, drives `in_rdy`, `out_rdy` and `half_full` to 0. The reset must be held for at least four edges of each clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en_hi | input | 1 | Active-high write qualifier |
| wr_en_lo_n | input | 1 | Active-low write qualifier |
| wr_data | input | DATA_W | Word to store |
| in_rdy | output | 1 | Space available; writes accepted while 1 |
| half_full | output | 1 | At least half the array occupied (write-side view) |
| rclk | input | 1 | Read-side clock |
| rd_take_n | input | 1 | Active-low read request |
| oe_a_n | input | 1 | Active-low output gate A |
| oe_b_n | input | 1 | Active-low output gate B |
| rd_data | output | DATA_W | Head word register |
| out_rdy | output | 1 | `rd_data` holds a valid, unread word |
| rd_drive | output | 1 | Output drive indication, 1 when both gates are open |

## Verification
The bench builds the block with DATA_W = 18 and ADDR_W = 4. This gives a 16-entry array and 17 words in flight, so full, half-full and pointer wraparound are each reached many times in a short run. The write clock runs at 5 ns and the read clock at 7 ns, with edges that never coincide, which makes the edge counts for the ready flags exact. Random phases alternate between slow and fast reading, so the block swings repeatedly between empty and full while a queue model checks every word.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b = g;
    for (int i = 1; i < 32; i++) b = b ^ (g >> i);
    return b;
  endfunction

endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
module dcf_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dcf_ram.sv
`timescale 1ns/1ps
module dcf_ram #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 8
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_wr_ctrl.sv
`timescale 1ns/1ps
module dcf_wr_ctrl
  import dcf_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ena_hi,
  input  logic              ena_lo_n,
  input  logic [ADDR_W:0]   rgray_s,
  output logic              in_rdy,
  output logic              half_full,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [ADDR_W:0]   wgray
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HALF  = DEPTH / 2;

  logic [PTR_W-1:0] wbin_q, wbin_nxt, wgray_q, wgray_nxt;
  logic [PTR_W-1:0] rbin_s, fill_nxt, full_pat;
  logic             full_q, full_nxt, hf_q, hf_nxt, fire;

  always_comb begin
    fire      = ena_hi & ~ena_lo_n & in_rdy;
    wbin_nxt  = wbin_q + PTR_W'(fire);
    wgray_nxt = PTR_W'(bin2gray(32'(wbin_nxt)));
    rbin_s    = PTR_W'(gray2bin(32'(rgray_s)));
    full_pat  = {~rgray_s[PTR_W-1:PTR_W-2], rgray_s[PTR_W-3:0]};
    full_nxt  = (wgray_nxt == full_pat);
    fill_nxt  = wbin_nxt - rbin_s;
    hf_nxt    = (fill_nxt >= PTR_W'(HALF));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      full_q  <= 1'b0;
      hf_q    <= 1'b0;
    end else begin
      if (fire) begin
        wbin_q  <= wbin_nxt;
        wgray_q <= wgray_nxt;
      end
      full_q <= full_nxt;
      hf_q   <= hf_nxt;
    end
  end

  assign in_rdy    = rst_n & ~full_q;
  assign half_full = hf_q;
  assign mem_we    = fire;
  assign mem_waddr = wbin_q[ADDR_W-1:0];
  assign wgray     = wgray_q;

  // R6: an attempt while not ready leaves the write pointer untouched
  p_blocked_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_hi && !ena_lo_n && !in_rdy) |=> (wbin_q == $past(wbin_q)));

  // R6: occupancy seen from the write side never exceeds the array depth
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((wbin_q - rbin_s) <= PTR_W'(DEPTH)));

  // R10: the crossing pointer changes at most one bit per edge
  p_wgray_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wgray_q ^ $past(wgray_q)));
endmodule

// File: rtl/dcf_rd_ctrl.sv
`timescale 1ns/1ps
module dcf_rd_ctrl
  import dcf_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_n,
  input  logic              gate_a_n,
  input  logic              gate_b_n,
  input  logic [ADDR_W:0]   wgray_s,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic [ADDR_W:0]   rgray,
  output logic              out_valid,
  output logic [DATA_W-1:0] dout,
  output logic              drive
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic [PTR_W-1:0]  rbin_q, rbin_nxt, rgray_q, rgray_nxt, wbin_s;
  logic [DATA_W-1:0] dout_q;
  logic              valid_q, valid_nxt, mem_empty, consume, load;

  always_comb begin
    mem_empty = (rgray_q == wgray_s);
    consume   = valid_q & ~take_n & ~gate_a_n & ~gate_b_n;
    load      = ~mem_empty & (~valid_q | consume);
    valid_nxt = load | (valid_q & ~consume);
    rbin_nxt  = rbin_q + PTR_W'(load);
    rgray_nxt = PTR_W'(bin2gray(32'(rbin_nxt)));
    wbin_s    = PTR_W'(gray2bin(32'(wgray_s)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      valid_q <= 1'b0;
      dout_q  <= '0;
    end else begin
      if (load) begin
        rbin_q  <= rbin_nxt;
        rgray_q <= rgray_nxt;
        dout_q  <= mem_rdata;
      end
      valid_q <= valid_nxt;
    end
  end

  assign mem_raddr = rbin_q[ADDR_W-1:0];
  assign rgray     = rgray_q;
  assign out_valid = valid_q;
  assign dout      = dout_q;
  assign drive     = ~gate_a_n & ~gate_b_n;

  // R2: an unconsumed head word stays valid and unchanged
  p_hold_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !consume) |=> (valid_q && $stable(dout_q)));

  // R7: consuming the last word drops ready and keeps the data
  p_keep_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && consume && mem_empty) |=> (!valid_q && $stable(dout_q)));

  // R10: the read pointer never passes the synchronized write pointer
  p_no_underrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((wbin_s - rbin_q) <= PTR_W'(DEPTH)));

  // R10: the crossing pointer changes at most one bit per edge
  p_rgray_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rgray_q ^ $past(rgray_q)));
endmodule

// File: rtl/dual_clk_fifo.sv
`timescale 1ns/1ps
module dual_clk_fifo #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 8
) (
  input  logic              wclk,
  input  logic              rst_n,
  input  logic              wr_en_hi,
  input  logic              wr_en_lo_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic              in_rdy,
  output logic              half_full,
  input  logic              rclk,
  input  logic              rd_take_n,
  input  logic              oe_a_n,
  input  logic              oe_b_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              out_rdy,
  output logic              rd_drive
);
  localparam int PTR_W = ADDR_W + 1;

  logic              wrst_n, rrst_n, mem_we;
  logic [PTR_W-1:0]  wgray, rgray, wgray_r, rgray_w;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [DATA_W-1:0] rdata;

  dcf_sync #(.W(1)) u_wrst (.clk(wclk), .arst_n(rst_n), .d(1'b1), .q(wrst_n));
  dcf_sync #(.W(1)) u_rrst (.clk(rclk), .arst_n(rst_n), .d(1'b1), .q(rrst_n));

  dcf_sync #(.W(PTR_W)) u_w2r (.clk(rclk), .arst_n(rrst_n), .d(wgray), .q(wgray_r));
  dcf_sync #(.W(PTR_W)) u_r2w (.clk(wclk), .arst_n(wrst_n), .d(rgray), .q(rgray_w));

  dcf_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .wclk(wclk), .we(mem_we), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(rdata)
  );

  dcf_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
    .clk(wclk), .rst_n(wrst_n), .ena_hi(wr_en_hi), .ena_lo_n(wr_en_lo_n),
    .rgray_s(rgray_w), .in_rdy(in_rdy), .half_full(half_full),
    .mem_we(mem_we), .mem_waddr(waddr), .wgray(wgray)
  );

  dcf_rd_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .clk(rclk), .rst_n(rrst_n), .take_n(rd_take_n), .gate_a_n(oe_a_n),
    .gate_b_n(oe_b_n), .wgray_s(wgray_r), .mem_rdata(rdata),
    .mem_raddr(raddr), .rgray(rgray), .out_valid(out_rdy),
    .dout(rd_data), .drive(rd_drive)
  );
endmodule

// File: tb/dual_clk_fifo_test.sv
`timescale 1ns/1ps
module dual_clk_fifo_test;
  localparam int DW = 18;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic wclk = 1'b0, rclk = 1'b0, rst_n;
  logic wr_en_hi, wr_en_lo_n, rd_take_n, oe_a_n, oe_b_n;
  logic [DW-1:0] wr_data;
  logic in_rdy, half_full, out_rdy, rd_drive;
  logic [DW-1:0] rd_data;

  int checks = 0, errors = 0, cyc = 0;
  int pushed = 0, popped = 0, acc_cnt = 0;
  logic [DW-1:0] model [$];
  logic [DW-1:0] last_rd = '0;
  bit have_last = 0;
  bit wr_done = 0;

  always #2.5 wclk = ~wclk;
  initial begin #0.7; forever #3.5 rclk = ~rclk; end

  dual_clk_fifo #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .wclk(wclk), .rst_n(rst_n), .wr_en_hi(wr_en_hi), .wr_en_lo_n(wr_en_lo_n),
    .wr_data(wr_data), .in_rdy(in_rdy), .half_full(half_full),
    .rclk(rclk), .rd_take_n(rd_take_n), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .rd_data(rd_data), .out_rdy(out_rdy), .rd_drive(rd_drive)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic wr_cycle(input logic hi, input logic lo_n, input logic [DW-1:0] d);
    @(negedge wclk);
    wr_en_hi = hi; wr_en_lo_n = lo_n; wr_data = d;
  endtask

  task automatic set_rd(input logic t, input logic a, input logic b);
    @(negedge rclk);
    rd_take_n = t; oe_a_n = a; oe_b_n = b;
  endtask

  // write-side model: R1 acceptance rule evaluated from the ports
  always @(negedge wclk) begin
    #1;
    if (rst_n && wr_en_hi && !wr_en_lo_n && in_rdy) begin
      model.push_back(wr_data);
      pushed++;
      acc_cnt++;
    end
  end

  // read-side model, compared on every read clock
  always @(negedge rclk) begin
    #1;
    if (rst_n) begin
      chk("R8", "rd_drive", rd_drive, (!oe_a_n && !oe_b_n));
      if (out_rdy) begin
        if (model.size() == 0) chk("R10", "ready with empty model", 1, 0);
        else begin
          chk("R10", "head word", rd_data, model[0]);
          if (!rd_take_n && !oe_a_n && !oe_b_n) begin   // R2 consumption rule
            last_rd = model.pop_front();
            have_last = 1;
            popped++;
          end
        end
      end else if (have_last) begin
        chk("R7", "held word while not ready", rd_data, last_rd);
      end
    end
  end

  always @(posedge wclk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R10 watchdog: actual %0d cycles expected below %0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] dctr;
    int guard;
    rst_n = 1'b0;
    wr_en_hi = 1'b1; wr_en_lo_n = 1'b0; wr_data = 18'h1111;
    rd_take_n = 1'b1; oe_a_n = 1'b1; oe_b_n = 1'b1;

    // R11: flags low throughout reset, even with write attempts
    repeat (5) @(posedge wclk);
    repeat (5) @(posedge rclk);
    #1;
    chk("R11", "in_rdy in reset", in_rdy, 0);
    chk("R11", "out_rdy in reset", out_rdy, 0);
    chk("R11", "half_full in reset", half_full, 0);

    // R5: release, ready on the second write edge
    @(negedge wclk);
    wr_en_hi = 1'b0; wr_en_lo_n = 1'b1;
    rst_n = 1'b1;
    @(posedge wclk); #1;
    chk("R5", "in_rdy after edge 1", in_rdy, 0);
    @(posedge wclk); #1;
    chk("R5", "in_rdy after edge 2", in_rdy, 1);
    repeat (4) @(posedge rclk);

    // R3/R4: fall-through with all read inputs inactive
    @(negedge wclk);
    wr_en_hi = 1'b1; wr_en_lo_n = 1'b0; wr_data = 18'h2A5A5;
    @(posedge wclk);
    fork begin @(negedge wclk); wr_en_hi = 1'b0; wr_en_lo_n = 1'b1; end join_none
    @(posedge rclk); #0.5;
    chk("R4", "out_rdy after read edge 1", out_rdy, 0);
    @(posedge rclk); #0.5;
    chk("R4", "out_rdy after read edge 2", out_rdy, 0);
    @(posedge rclk); #0.5;
    chk("R4", "out_rdy after read edge 3", out_rdy, 1);
    chk("R3", "fall-through word", rd_data, 18'h2A5A5);

    // R8/R2: any inactive read input keeps the head word
    set_rd(0, 1, 0);
    repeat (4) @(posedge rclk); #0.5;
    chk("R8", "gate A blocks read", out_rdy, 1);
    chk("R8", "gate A holds data", rd_data, 18'h2A5A5);
    set_rd(0, 0, 1);
    repeat (4) @(posedge rclk); #0.5;
    chk("R8", "gate B blocks read", out_rdy, 1);
    set_rd(1, 0, 0);
    repeat (4) @(posedge rclk); #0.5;
    chk("R2", "no request holds word", rd_data, 18'h2A5A5);
    chk("R8", "drive with gates open", rd_drive, 1);
    set_rd(1, 1, 1);

    // R1: wrong qualifier combinations store nothing
    repeat (10) @(posedge wclk);
    acc_cnt = 0;
    wr_cycle(1, 1, 18'h00AA);
    wr_cycle(0, 0, 18'h00BB);
    wr_cycle(0, 1, 18'h00CC);
    wr_cycle(1, 1, 18'h00DD);
    wr_cycle(0, 1, 18'h0000);
    @(posedge wclk); #1;
    chk("R1", "accepts with bad qualifiers", acc_cnt, 0);
    chk("R1", "in_rdy still high", in_rdy, 1);

    // R6/R9: fill the array, then keep attempting
    dctr = 18'h100;
    for (int i = 0; i < 40; i++) begin
      wr_cycle(1, 0, dctr);
      dctr = dctr + 1'b1;
    end
    wr_cycle(0, 1, '0);
    @(posedge wclk); #1;
    chk("R6", "words accepted into array", acc_cnt, DEPTH);
    chk("R6", "in_rdy when full", in_rdy, 0);
    chk("R9", "half_full when full", half_full, 1);

    // drain everything
    set_rd(0, 0, 0);
    guard = 0;
    while ((model.size() != 0 || out_rdy) && guard < 400) begin
      @(posedge rclk); guard++;
    end
    repeat (3) @(posedge rclk); #1;
    chk("R10", "model empty after drain", model.size(), 0);
    chk("R7", "last word held", rd_data, last_rd);
    chk("R7", "out_rdy after drain", out_rdy, 0);
    repeat (10) @(posedge wclk); #1;
    chk("R9", "half_full after drain", half_full, 0);
    chk("R6", "in_rdy after drain", in_rdy, 1);

    // R10: random traffic, alternating slow and fast reading
    fork
      begin
        for (int i = 0; i < 3000; i++)
          wr_cycle(($urandom % 8) != 0, ($urandom % 8) == 0, DW'($urandom));
        wr_cycle(0, 1, '0);
        wr_done = 1;
      end
      begin
        int n;
        n = 0;
        while (!(wr_done && model.size() == 0 && !out_rdy) && n < 40000) begin
          if (wr_done) set_rd(0, 0, 0);
          else if (((n / 300) % 2) == 1)
            set_rd(($urandom % 4) != 0, ($urandom % 6) == 0, ($urandom % 6) == 0);
          else
            set_rd(($urandom % 8) == 0, ($urandom % 10) == 0, ($urandom % 10) == 0);
          n++;
        end
      end
    join
    repeat (5) @(posedge rclk); #1;
    chk("R10", "words delivered equal words accepted", popped, pushed);
    chk("R10", "model empty at end", model.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule